// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

This block is a synthesizable on-chip model of a synchronous static RAM with a burst address sequencer. Address, chip enables, strobes, write controls and write data are sampled on the rising clock edge. Read data flows straight from the array to the output in the cycle after the edge that registered the address, with no output pipeline register.

A cycle starts from one of two address strobes. The processor-style strobe always begins a read and takes precedence. The controller-style strobe begins either a write or a read, depending on the write controls. When neither strobe is active, an advance input either steps the burst through four addresses or holds the current address. Holding the address inserts wait states.

Each of the four data lanes holds 8 data bits and 1 parity bit. A lane can be written on its own under a lane strobe. A global write overrides the lane strobes and writes every lane. Output enable and sleep act on the output without waiting for a clock edge.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset the block is deselected and no burst is active. While no strobe selects it, `rvalid_o` stays 0 and `rdata_o` reads zero.
- R2: The chip is selected only when `sel_a_n_i`=0, `sel_b_i`=1 and `sel_c_n_i`=0 are sampled together. A strobe sampled with any other combination gives a deselect cycle. `rvalid_o` is 0 from the next cycle, and the block stays deselected through later advance or hold cycles. Writes requested in those cycles are not committed.
- R3: While `sel_a_n_i`=1, a low `strobe_proc_n_i` is ignored. If `strobe_ctrl_n_i` is also high, the cycle is a normal advance or hold cycle of the current burst.
- R4: `strobe_proc_n_i`=0 with `sel_a_n_i`=0 and the chip selected loads `addr_i` and starts a read, whatever the write controls say. It takes precedence over `strobe_ctrl_n_i`.
- R5: `strobe_ctrl_n_i`=0, with the processor strobe not in effect and the chip selected, loads `addr_i`. The cycle is a write to that address if a write is requested, and a read otherwise.
- R6: A write is requested when `all_wr_n_i`=0, or when `lane_wr_en_n_i`=0 and at least one bit of `lane_wr_n_i` is 0. `all_wr_n_i`=0 writes every lane regardless of `lane_wr_n_i`. In all other cases the cycle is a read.
- R7: In a lane write, bit k of `lane_wr_n_i` equal to 0 writes data bits [9k+8:9k] (8 data bits and their parity bit). The other lanes keep their contents.
- R8: With both strobes high, `burst_step_n_i`=0 advances the burst and `burst_step_n_i`=1 holds the current address. Either kind of cycle may be a read or a write. With `burst_order_i`=0 (linear), the two low address bits of step n are (start + n) mod 4. The upper address bits never change within a burst, so the burst wraps after four addresses.
- R9: With `burst_order_i`=1 (interleaved), the two low address bits of step n are start XOR n.
- R10: Reads are flow-through. The word at the address registered at an edge is on `rdata_o` before the next edge. `rvalid_o` is 1 only for a selected read cycle with `out_en_n_i`=0 and `sleep_i`=0, and these two inputs act without a clock edge. `rdata_o` is zero whenever `rvalid_o` is 0.
- R11: While `sleep_i`=1, all synchronous inputs are ignored: nothing is written, and neither the burst address nor the cycle state changes. `rvalid_o` is 0 during sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | External word address |
| strobe_proc_n_i | input | 1 | Processor-style address strobe, active low |
| strobe_ctrl_n_i | input | 1 | Controller-style address strobe, active low |
| burst_step_n_i | input | 1 | Burst advance (0) or hold (1) |
| sel_a_n_i | input | 1 | Chip enable, active low; also gates the processor strobe |
| sel_b_i | input | 1 | Chip enable, active high |
| sel_c_n_i | input | 1 | Chip enable, active low |
| all_wr_n_i | input | 1 | Global write, active low |
| lane_wr_en_n_i | input | 1 | Lane write enable, active low |
| lane_wr_n_i | input | LANES | Per-lane write strobes, active low |
| out_en_n_i | input | 1 | Output enable, active low, asynchronous |
| sleep_i | input | 1 | Sleep, active high, asynchronous |
| burst_order_i | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Read data, zero when not valid |
| rvalid_o | output | 1 | Read data valid |

## Verification
Four-word bursts are run with both orders from a non-aligned start address. A start of 1 gives a different sequence in each order, so a swapped or wrong sequencer shows up, and wrap-around and hold cycles are covered within the same bursts. Partial-lane writes use several masks and are read back, which separates correct lane masking from whole-word writes. The write-control combinations that only look like writes are run to confirm they behave as reads. The strobe patterns cover both strobes low, the processor strobe gated by the first chip enable, each chip-enable combination that deselects, and sleep and output enable. These tell apart the precedence between the strobes, the decoding of the chip select, and the asynchronous gating of the output.

// File: rtl/sram_pkg.sv
package sram_pkg;

    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        CYC_START = 2'd0,
        CYC_CONT  = 2'd1,
        CYC_SLEEP = 2'd2
    } cyc_e;

endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq #(
    parameter int CW = 2
) (
    input  logic [CW-1:0] start_i,
    input  logic [CW-1:0] step_i,
    input  logic          order_i,
    output logic [CW-1:0] lsb_o
);

    logic [CW-1:0] lin_lsb;
    logic [CW-1:0] xor_lsb;

    assign lin_lsb = start_i + step_i;
    assign xor_lsb = start_i ^ step_i;
    assign lsb_o   = order_i ? xor_lsb : lin_lsb;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 4,
    parameter int CW    = BURST_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr_i,
    input  logic             strobe_proc_n_i,
    input  logic             strobe_ctrl_n_i,
    input  logic             burst_step_n_i,
    input  logic             sel_a_n_i,
    input  logic             sel_b_i,
    input  logic             sel_c_n_i,
    input  logic             all_wr_n_i,
    input  logic             lane_wr_en_n_i,
    input  logic [LANES-1:0] lane_wr_n_i,
    input  logic             sleep_i,
    input  logic             order_i,
    output logic             we_o,
    output logic [LANES-1:0] lane_en_o,
    output logic [AW-1:0]    waddr_o,
    output logic [AW-1:0]    raddr_o,
    output logic             rd_cycle_o
);

    typedef struct packed {
        logic          active;
        logic          is_read;
        logic [AW-1:0] base;
        logic [CW-1:0] step;
    } st_t;

    st_t           st_q;
    st_t           st_d;
    cyc_e          kind;
    logic          sel_ok;
    logic          proc_hit;
    logic          start_hit;
    logic          wr_req;
    logic          we_d;
    logic [LANES-1:0] mask_d;
    logic [CW-1:0] lsb_d;
    logic [CW-1:0] lsb_q;

    always_comb begin
        st_d      = st_q;
        we_d      = 1'b0;
        sel_ok    = !sel_a_n_i && sel_b_i && !sel_c_n_i;
        proc_hit  = !strobe_proc_n_i && !sel_a_n_i;
        start_hit = proc_hit || !strobe_ctrl_n_i;
        wr_req    = !all_wr_n_i || (!lane_wr_en_n_i && !(&lane_wr_n_i));
        if (!all_wr_n_i) begin
            mask_d = '1;
        end else if (!lane_wr_en_n_i) begin
            mask_d = ~lane_wr_n_i;
        end else begin
            mask_d = '0;
        end

        if (sleep_i) begin
            kind = CYC_SLEEP;
        end else if (start_hit) begin
            kind = CYC_START;
        end else begin
            kind = CYC_CONT;
        end

        case (kind)
            CYC_START: begin
                if (sel_ok) begin
                    st_d.active  = 1'b1;
                    st_d.base    = addr_i;
                    st_d.step    = '0;
                    st_d.is_read = proc_hit || !wr_req;
                    we_d         = !proc_hit && wr_req;
                end else begin
                    st_d.active  = 1'b0;
                    st_d.is_read = 1'b0;
                end
            end
            CYC_CONT: begin
                if (st_q.active) begin
                    st_d.step    = st_q.step + CW'(!burst_step_n_i);
                    st_d.is_read = !wr_req;
                    we_d         = wr_req;
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sram_burst_seq #(.CW(CW)) u_seq_d (
        .start_i (st_d.base[CW-1:0]),
        .step_i  (st_d.step),
        .order_i (order_i),
        .lsb_o   (lsb_d)
    );

    sram_burst_seq #(.CW(CW)) u_seq_q (
        .start_i (st_q.base[CW-1:0]),
        .step_i  (st_q.step),
        .order_i (order_i),
        .lsb_o   (lsb_q)
    );

    assign we_o       = we_d;
    assign lane_en_o  = mask_d;
    assign waddr_o    = {st_d.base[AW-1:CW], lsb_d};
    assign raddr_o    = {st_q.base[AW-1:CW], lsb_q};
    assign rd_cycle_o = st_q.active && st_q.is_read;

endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int DEPTH  = 256,
    parameter int AW     = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [LANES-1:0] lane_en_i,
    input  logic [AW-1:0]    waddr_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [AW-1:0]    raddr_i,
    output logic [DW-1:0]    rdata_o
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we_i && lane_en_i[l]) begin
                mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
            end
        end

        assign rdata_o[l*LANE_W +: LANE_W] = mem[raddr_i];
    end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sram_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr_i,
    input  logic             strobe_proc_n_i,
    input  logic             strobe_ctrl_n_i,
    input  logic             burst_step_n_i,
    input  logic             sel_a_n_i,
    input  logic             sel_b_i,
    input  logic             sel_c_n_i,
    input  logic             all_wr_n_i,
    input  logic             lane_wr_en_n_i,
    input  logic [LANES-1:0] lane_wr_n_i,
    input  logic             out_en_n_i,
    input  logic             sleep_i,
    input  logic             burst_order_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    output logic             rvalid_o
);

    logic             we;
    logic [LANES-1:0] lane_en;
    logic [AW-1:0]    waddr;
    logic [AW-1:0]    raddr;
    logic             rd_cycle;
    logic [DW-1:0]    arr_rd;

    sram_ctrl #(.AW(AW), .LANES(LANES), .CW(BURST_W)) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .addr_i          (addr_i),
        .strobe_proc_n_i (strobe_proc_n_i),
        .strobe_ctrl_n_i (strobe_ctrl_n_i),
        .burst_step_n_i  (burst_step_n_i),
        .sel_a_n_i       (sel_a_n_i),
        .sel_b_i         (sel_b_i),
        .sel_c_n_i       (sel_c_n_i),
        .all_wr_n_i      (all_wr_n_i),
        .lane_wr_en_n_i  (lane_wr_en_n_i),
        .lane_wr_n_i     (lane_wr_n_i),
        .sleep_i         (sleep_i),
        .order_i         (burst_order_i),
        .we_o            (we),
        .lane_en_o       (lane_en),
        .waddr_o         (waddr),
        .raddr_o         (raddr),
        .rd_cycle_o      (rd_cycle)
    );

    sram_array #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk       (clk),
        .we_i      (we),
        .lane_en_i (lane_en),
        .waddr_i   (waddr),
        .wdata_i   (wdata_i),
        .raddr_i   (raddr),
        .rdata_o   (arr_rd)
    );

    assign rvalid_o = rd_cycle && !out_en_n_i && !sleep_i;
    assign rdata_o  = rvalid_o ? arr_rd : '0;

endmodule

// File: rtl/sram_chk.sv
module sram_chk #(
    parameter int LANES = 4,
    parameter int DW    = 36
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strobe_proc_n_i,
    input logic             strobe_ctrl_n_i,
    input logic             burst_step_n_i,
    input logic             sel_a_n_i,
    input logic             sel_b_i,
    input logic             sel_c_n_i,
    input logic             all_wr_n_i,
    input logic             lane_wr_en_n_i,
    input logic [LANES-1:0] lane_wr_n_i,
    input logic             out_en_n_i,
    input logic             sleep_i,
    input logic [DW-1:0]    rdata_o,
    input logic             rvalid_o
);

    logic selected;
    logic wr_req;
    logic strobe_on;

    assign selected  = !sel_a_n_i && sel_b_i && !sel_c_n_i;
    assign wr_req    = !all_wr_n_i || (!lane_wr_en_n_i && (lane_wr_n_i != '1));
    assign strobe_on = (!strobe_proc_n_i && !sel_a_n_i) || !strobe_ctrl_n_i;

    // R2: a strobe with an unselected chip leaves no valid read next cycle
    assert_dsel_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_on && !selected && !sleep_i) |=> !rvalid_o);

    // R4: processor strobe on a selected chip always gives a read
    assert_proc_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_proc_n_i && !sel_a_n_i && selected && !sleep_i)
        |=> (rvalid_o || out_en_n_i || sleep_i));

    // R5: controller strobe with a write request is not a read
    assert_ctrl_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_ctrl_n_i && strobe_proc_n_i && selected && wr_req && !sleep_i)
        |=> !rvalid_o);

    // R8: a hold cycle without a write keeps the output word
    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid_o && strobe_proc_n_i && strobe_ctrl_n_i && burst_step_n_i
         && !wr_req && !sleep_i && !out_en_n_i)
        |=> (!rvalid_o || $stable(rdata_o)));

    // R10: invalid output reads zero
    assert_zero_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid_o |-> (rdata_o == '0));

    // R11: a read stays invalid while asleep
    assert_sleep_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && $past(sleep_i)) |-> !rvalid_o);

endmodule

bind sync_burst_sram sram_chk #(.LANES(LANES), .DW(DW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .strobe_proc_n_i (strobe_proc_n_i),
    .strobe_ctrl_n_i (strobe_ctrl_n_i),
    .burst_step_n_i  (burst_step_n_i),
    .sel_a_n_i       (sel_a_n_i),
    .sel_b_i         (sel_b_i),
    .sel_c_n_i       (sel_c_n_i),
    .all_wr_n_i      (all_wr_n_i),
    .lane_wr_en_n_i  (lane_wr_en_n_i),
    .lane_wr_n_i     (lane_wr_n_i),
    .out_en_n_i      (out_en_n_i),
    .sleep_i         (sleep_i),
    .rdata_o         (rdata_o),
    .rvalid_o        (rvalid_o)
);

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb;

    localparam int CLK_P = 10;
    localparam int DEPTH = 256;
    localparam int AW    = 8;
    localparam int DW    = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_i;
    logic          strobe_proc_n_i, strobe_ctrl_n_i, burst_step_n_i;
    logic          sel_a_n_i, sel_b_i, sel_c_n_i;
    logic          all_wr_n_i, lane_wr_en_n_i;
    logic [3:0]    lane_wr_n_i;
    logic          out_en_n_i, sleep_i, burst_order_i;
    logic [DW-1:0] wdata_i;
    logic [DW-1:0] rdata_o;
    logic          rvalid_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        bit            v;
        logic [DW-1:0] d;
        string         tag;
    } exp_t;

    exp_t          sb_q[$];
    logic [DW-1:0] model [DEPTH];

    always #(CLK_P/2) clk = ~clk;

    sync_burst_sram u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
        .strobe_proc_n_i(strobe_proc_n_i), .strobe_ctrl_n_i(strobe_ctrl_n_i),
        .burst_step_n_i(burst_step_n_i), .sel_a_n_i(sel_a_n_i),
        .sel_b_i(sel_b_i), .sel_c_n_i(sel_c_n_i), .all_wr_n_i(all_wr_n_i),
        .lane_wr_en_n_i(lane_wr_en_n_i), .lane_wr_n_i(lane_wr_n_i),
        .out_en_n_i(out_en_n_i), .sleep_i(sleep_i),
        .burst_order_i(burst_order_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .rvalid_o(rvalid_o)
    );

    function automatic logic [DW-1:0] pat(int a, int salt);
        return DW'(a * 36'h1_0305 ^ salt * 36'h9_A5C3_1E7 ^ 36'h5_0000_0000);
    endfunction

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                            logic [3:0] wr_n);
        logic [DW-1:0] r = old;
        for (int k = 0; k < 4; k++) begin
            if (!wr_n[k]) r[k*9 +: 9] = nw[k*9 +: 9];
        end
        return r;
    endfunction

    task automatic idle_sig();
        addr_i = '0; strobe_proc_n_i = 1; strobe_ctrl_n_i = 1; burst_step_n_i = 1;
        sel_a_n_i = 0; sel_b_i = 1; sel_c_n_i = 0; all_wr_n_i = 1;
        lane_wr_en_n_i = 1; lane_wr_n_i = 4'hF; out_en_n_i = 0; sleep_i = 0;
        wdata_i = 36'h0_DEAD_BEEF;
    endtask

    task automatic tick(string tag, bit ev, int ea);
        exp_t it;
        it.v = ev;
        it.d = ev ? model[ea] : '0;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic wr_start(string tag, int a, logic [DW-1:0] d, logic [3:0] wr_n, bit use_all);
        idle_sig();
        strobe_ctrl_n_i = 0; addr_i = AW'(a); wdata_i = d;
        if (use_all) begin
            all_wr_n_i = 0; model[a] = d;
        end else begin
            lane_wr_en_n_i = 0; lane_wr_n_i = wr_n; model[a] = merge(model[a], d, wr_n);
        end
        tick(tag, 0, 0);
    endtask

    task automatic wr_cont(string tag, int a, logic [DW-1:0] d, bit adv);
        idle_sig();
        burst_step_n_i = !adv; all_wr_n_i = 0; wdata_i = d; model[a] = d;
        tick(tag, 0, 0);
    endtask

    task automatic rd_start(string tag, int a);
        idle_sig();
        strobe_proc_n_i = 0; addr_i = AW'(a); all_wr_n_i = 0; // R4: write controls ignored
        tick(tag, 1, a);
    endtask

    task automatic rd_cont(string tag, int a, bit adv);
        idle_sig();
        burst_step_n_i = !adv;
        tick(tag, 1, a);
    endtask

    // monitor: compares each driven cycle after the edge that registered it
    always @(posedge clk) begin
        #(CLK_P/4);
        if (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            checks++;
            if (rvalid_o !== it.v || rdata_o !== it.d) begin
                failures++;
                $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
                         it.tag, rvalid_o, rdata_o, it.v, it.d);
            end
        end
    end

    initial begin
        #(CLK_P * 4000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        burst_order_i = 0;
        idle_sig();
        repeat (3) @(negedge clk);
        rst_n = 1;

        idle_sig(); tick("R1 idle after reset", 0, 0);
        idle_sig(); tick("R1 still deselected", 0, 0);

        // linear write burst then read burst
        wr_start("R5 ctrl write start", 16, pat(16, 1), 4'hF, 1);
        wr_cont("R8 write advance", 17, pat(17, 1), 1);
        wr_cont("R8 write advance", 18, pat(18, 1), 1);
        wr_cont("R8 write advance", 19, pat(19, 1), 1);
        rd_start("R4 proc read ignores write controls", 16);
        rd_cont("R8 linear 1", 17, 1);
        rd_cont("R8 linear 2", 18, 1);
        rd_cont("R8 linear 3", 19, 1);
        rd_cont("R8 wrap", 16, 1);
        rd_cont("R8 hold", 16, 0);
        rd_cont("R8 advance after hold", 17, 1);

        // order check from start 1 within a block
        for (int a = 32; a < 36; a++) wr_start("R5 single write", a, pat(a, 2), 4'hF, 1);
        burst_order_i = 1;
        rd_start("R9 xor start", 33);
        rd_cont("R9 xor 1", 32, 1);
        rd_cont("R9 xor 2", 35, 1);
        rd_cont("R9 xor 3", 34, 1);
        burst_order_i = 0;
        rd_start("R8 linear start", 33);
        rd_cont("R8 linear from 1", 34, 1);
        rd_cont("R8 linear from 1", 35, 1);
        rd_cont("R8 linear wrap from 1", 32, 1);

        // lane writes
        wr_start("R7 lane0 only", 16, pat(90, 3), 4'b1110, 0);
        rd_start("R7 read lane0 merge", 16);
        wr_start("R7 lanes1 and 3", 17, pat(91, 3), 4'b0101, 0);
        rd_start("R7 read lanes1/3 merge", 17);
        idle_sig();
        strobe_ctrl_n_i = 0; addr_i = 8'd18; all_wr_n_i = 0; lane_wr_en_n_i = 0;
        wdata_i = pat(92, 3); model[18] = pat(92, 3);
        tick("R6 global write overrides lanes", 0, 0);
        rd_start("R6 read global write", 18);

        // look-alike writes are reads
        idle_sig(); strobe_ctrl_n_i = 0; addr_i = 8'd19; lane_wr_en_n_i = 0;
        tick("R6 enable without lane is read", 1, 19);
        idle_sig(); strobe_ctrl_n_i = 0; addr_i = 8'd18; lane_wr_n_i = 4'h0;
        tick("R6 lanes without enable is read", 1, 18);
        idle_sig(); strobe_ctrl_n_i = 0; strobe_proc_n_i = 0; addr_i = 8'd17;
        all_wr_n_i = 0; tick("R4 precedence over ctrl", 1, 17);

        // deselect
        wr_start("R5 setup 20", 20, pat(20, 4), 4'hF, 1);
        wr_start("R5 setup 21", 21, pat(21, 4), 4'hF, 1);
        idle_sig(); strobe_ctrl_n_i = 0; sel_b_i = 0; addr_i = 8'd20; all_wr_n_i = 0;
        tick("R2 deselect by second enable", 0, 0);
        idle_sig(); burst_step_n_i = 0; all_wr_n_i = 0;
        tick("R2 continue while deselected", 0, 0);
        idle_sig(); all_wr_n_i = 0;
        tick("R2 hold while deselected", 0, 0);
        rd_start("R2 no write while deselected", 20);
        rd_cont("R2 no write while deselected", 21, 1);
        idle_sig(); strobe_proc_n_i = 0; sel_c_n_i = 1; addr_i = 8'd20;
        tick("R2 deselect by third enable", 0, 0);
        idle_sig(); strobe_ctrl_n_i = 0; sel_a_n_i = 1; addr_i = 8'd20;
        tick("R2 deselect by first enable", 0, 0);

        // processor strobe gated by first enable
        rd_start("R3 setup burst", 16);
        idle_sig(); sel_a_n_i = 1; strobe_proc_n_i = 0; addr_i = 8'd40;
        tick("R3 proc ignored, hold", 1, 16);
        idle_sig(); sel_a_n_i = 1; strobe_proc_n_i = 0; addr_i = 8'd40; burst_step_n_i = 0;
        tick("R3 proc ignored, advance", 1, 17);

        // output enable and sleep
        idle_sig(); out_en_n_i = 1;
        tick("R10 output enable high", 0, 0);
        rd_cont("R10 output enable low again", 17, 0);
        idle_sig(); sleep_i = 1; strobe_ctrl_n_i = 0; addr_i = 8'd17; all_wr_n_i = 0;
        tick("R11 asleep, write ignored", 0, 0);
        idle_sig(); sleep_i = 1; burst_step_n_i = 0;
        tick("R11 asleep, no advance", 0, 0);
        rd_cont("R11 awake, same address and data", 17, 0);

        idle_sig();
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule